// File: doc/BRIEF.md
# Calibrated Window Search Controller

This block tunes a sigma-delta converter to a chosen output span without any division. It owns the calibration pin of the analog front end and the length of the window over which the front end counts. Starting from a loadable initial window, it measures the converter twice per pass. The first measurement uses the pin driven to the zero-scale level. The second uses the pin driven to the full-scale level. The difference between the two readings is compared with a loadable target range, and the window is moved up or down by a step that halves on every pass. The search stops when the difference hits the target exactly, or when the step runs out.

Every change of calibration level is followed by a soak period, so that the filter capacitors can settle before a reading is taken. Once tuned, the block stops driving the calibration pin. It then requests conversions back to back and delivers each reading with the stored zero-scale reading removed and clamped into the range 0 to the target. A recalibration request restarts the whole search at any time.

Top module: `span_cal_ctrl`

## Requirements
- R1: On reset release, or in the cycle after `recalReq`, the block samples `cfgWindowInit` and `cfgTarget`. The window starts at the initial value and the step at the initial value shifted right by one. During the search `busy` is 1 and `calibrated` is 0.
- R2: Every search pass takes exactly two readings: first with `calEnable`=1 and `calDrive`=0 (zero scale), then with `calEnable`=1 and `calDrive`=1 (full scale). Each reading is requested by a single-cycle `acqStart` pulse, with `acqWindow` carrying the current window, and it completes on `acqDone`.
- R3: `acqStart` for a calibration reading rises no sooner than SOAK_CYCLES clocks after the calibration level was last changed.
- R4: When full-scale reading minus zero-scale reading equals the target, the search ends after that pass and the window is left unchanged.
- R5: The span is formed as a signed difference. When it is greater than the target, the step is subtracted from the window; otherwise the step is added.
- R6: After each adjustment the step is shifted right by one, and the search ends once the shifted step is zero.
- R7: When the search ends, `calEnable` drops to 0, `busy` drops and `calibrated` rises. Conversions are then requested continuously: the first `acqStart` comes in the same cycle `calibrated` rises, and each later one comes in the cycle after the previous `acqDone`. All of them use the final window.
- R8: After calibration, each `acqDone` produces a one-cycle `outValid` in the following cycle. `outData` equals the raw reading minus the stored zero-scale reading, taken as a signed value and clamped to 0 below and to the target above.
- R9: A `recalReq` in any state abandons the current activity. In the next cycle `busy`=1, `calibrated`=0, and no conversion request is issued.
- R10: Changes of `cfgTarget` or `cfgWindowInit` outside the sampling points of R1 have no effect on the window or on the clamp limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgTarget | input | W | Desired span between full-scale and zero-scale readings |
| cfgWindowInit | input | W | Starting window length for the search |
| recalReq | input | 1 | Restart the calibration search |
| acqStart | output | 1 | One-cycle conversion request to the front end |
| acqWindow | output | W | Window length for the requested conversion |
| acqDone | input | 1 | Front end reading is valid this cycle |
| acqValue | input | W | Raw count from the front end |
| calEnable | output | 1 | 1: drive the calibration level; 0: release the pin |
| calDrive | output | 1 | Calibration level, 0 zero scale, 1 full scale |
| busy | output | 1 | Search in progress |
| calibrated | output | 1 | Search finished, conversions running |
| outValid | output | 1 | Corrected reading valid this cycle |
| outData | output | W | Offset-corrected, clamped reading |

## Verification
The hardest situation to reach is a recalibration that arrives while a run-phase conversion is still in flight. The late `acqDone` then lands during the new search's soak, and it must be ignored without corrupting the zero-scale value or the pass order. The stimulus reaches this by pulsing `recalReq` while the front-end model is still holding back a reply for a random latency. The bench then checks that the new search requests exactly two readings per expected pass, in low-then-high order, and ends on the window that an independent model of the search predicts. Directed cases cover an exact match on the first pass, an initial window of 1 (zero step), and a target too large to reach, in which case the step runs out.

// File: rtl/wcal_pkg.sv
package wcal_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_SOAK_LO,
    ST_ACQ_LO,
    ST_SOAK_HI,
    ST_ACQ_HI,
    ST_DECIDE,
    ST_RUN
  } wcal_state_e;

  typedef struct packed {
    logic load;     // sample configuration, restart window and step
    logic capLow;   // store zero-scale reading
    logic capHigh;  // form span from full-scale reading
    logic adjust;   // move window by step, halve step
    logic capOut;   // register corrected reading
  } wcal_strobe_t;

endpackage

// File: rtl/wcal_dp.sv
module wcal_dp
  import wcal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  wcal_strobe_t stb,
  input  logic [W-1:0] cfgTarget,
  input  logic [W-1:0] cfgWindowInit,
  input  logic [W-1:0] acqValue,
  output logic [W-1:0] window,
  output logic         spanMatch,
  output logic         lastStep,
  output logic         outValid,
  output logic [W-1:0] outData
);

  localparam int SW = W + 1;

  logic [W-1:0]         step;
  logic [W-1:0]         lowVal;
  logic [W-1:0]         target;
  logic signed [SW-1:0] span;
  logic signed [SW-1:0] rawDiff;
  logic signed [SW-1:0] targetS;
  logic [W-1:0]         clamped;

  assign targetS = $signed({1'b0, target});
  assign rawDiff = $signed({1'b0, acqValue}) - $signed({1'b0, lowVal});

  always_comb begin
    if (rawDiff < 0)            clamped = '0;
    else if (rawDiff > targetS) clamped = target;
    else                        clamped = rawDiff[W-1:0];
  end

  assign spanMatch = (span == targetS);
  assign lastStep  = ((step >> 1) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window   <= '0;
      step     <= '0;
      target   <= '0;
      lowVal   <= '0;
      span     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.load) begin
        window <= cfgWindowInit;
        step   <= cfgWindowInit >> 1;
        target <= cfgTarget;
      end else if (stb.adjust) begin
        if (span > targetS) window <= window - step;
        else                window <= window + step;
        step <= step >> 1;
      end
      if (stb.capLow)  lowVal <= acqValue;
      if (stb.capHigh) span   <= rawDiff;
      outValid <= stb.capOut;
      if (stb.capOut) outData <= clamped;
    end
  end

  // the controller must never move the window after an exact span hit
  assert_no_adjust_on_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.adjust |-> !spanMatch);

  // delivered readings never exceed the sampled target
  assert_clamp_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData <= target));

endmodule

// File: rtl/wcal_ctrl.sv
module wcal_ctrl
  import wcal_pkg::*;
#(
  parameter int SOAK_CYCLES = 40000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         recalReq,
  input  logic         acqDone,
  input  logic         spanMatch,
  input  logic         lastStep,
  output wcal_strobe_t stb,
  output logic         acqStart,
  output logic         calEnable,
  output logic         calDrive,
  output logic         busy,
  output logic         calibrated
);

  localparam int CW = $clog2(SOAK_CYCLES + 1);
  localparam logic [CW-1:0] SOAK_LAST = CW'(SOAK_CYCLES - 1);
  localparam logic [CW-1:0] SOAK_FULL = CW'(SOAK_CYCLES);

  wcal_state_e   state, nextState;
  logic [CW-1:0] soakCnt;
  logic          startNext;

  always_comb begin
    stb       = '0;
    nextState = state;
    startNext = 1'b0;
    case (state)
      ST_INIT: begin
        stb.load  = 1'b1;
        nextState = ST_SOAK_LO;
      end
      ST_SOAK_LO: if (soakCnt == SOAK_LAST) begin
        nextState = ST_ACQ_LO;
        startNext = 1'b1;
      end
      ST_ACQ_LO: if (acqDone) begin
        stb.capLow = 1'b1;
        nextState  = ST_SOAK_HI;
      end
      ST_SOAK_HI: if (soakCnt == SOAK_LAST) begin
        nextState = ST_ACQ_HI;
        startNext = 1'b1;
      end
      ST_ACQ_HI: if (acqDone) begin
        stb.capHigh = 1'b1;
        nextState   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (spanMatch) begin
          nextState = ST_RUN;
          startNext = 1'b1;
        end else begin
          stb.adjust = 1'b1;
          if (lastStep) begin
            nextState = ST_RUN;
            startNext = 1'b1;
          end else begin
            nextState = ST_SOAK_LO;
          end
        end
      end
      ST_RUN: if (acqDone) begin
        stb.capOut = 1'b1;
        startNext  = 1'b1;
      end
      default: nextState = ST_INIT;
    endcase
    if (recalReq) begin
      stb       = '0;
      nextState = ST_INIT;
      startNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_INIT;
      soakCnt  <= '0;
      acqStart <= 1'b0;
    end else begin
      state    <= nextState;
      acqStart <= startNext;
      if (nextState != state) soakCnt <= '0;
      else if (state == ST_SOAK_LO || state == ST_SOAK_HI) soakCnt <= soakCnt + 1'b1;
    end
  end

  assign calEnable  = (state != ST_RUN);
  assign calDrive   = (state == ST_SOAK_HI) || (state == ST_ACQ_HI);
  assign busy       = (state != ST_RUN);
  assign calibrated = (state == ST_RUN);

  // independent age of the calibration level, saturating
  logic [CW-1:0] lvlAge;
  logic [1:0]    lvlPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlAge  <= '0;
      lvlPrev <= 2'b10;
    end else begin
      lvlPrev <= {calEnable, calDrive};
      if ({calEnable, calDrive} != lvlPrev) lvlAge <= '0;
      else if (lvlAge != SOAK_FULL)         lvlAge <= lvlAge + 1'b1;
    end
  end

  assert_soak_before_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acqStart && calEnable) |-> (lvlAge >= SOAK_LAST));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> !acqStart);

  assert_first_run_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calibrated) |-> acqStart);

  assert_recal_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    recalReq |=> (busy && !calibrated && !acqStart));

endmodule

// File: rtl/span_cal_ctrl.sv
module span_cal_ctrl
  import wcal_pkg::*;
#(
  parameter int W           = 16,
  parameter int SOAK_CYCLES = 40000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cfgTarget,
  input  logic [W-1:0] cfgWindowInit,
  input  logic         recalReq,
  output logic         acqStart,
  output logic [W-1:0] acqWindow,
  input  logic         acqDone,
  input  logic [W-1:0] acqValue,
  output logic         calEnable,
  output logic         calDrive,
  output logic         busy,
  output logic         calibrated,
  output logic         outValid,
  output logic [W-1:0] outData
);

  wcal_strobe_t stb;
  logic         spanMatch;
  logic         lastStep;

  wcal_ctrl #(.SOAK_CYCLES(SOAK_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .recalReq   (recalReq),
    .acqDone    (acqDone),
    .spanMatch  (spanMatch),
    .lastStep   (lastStep),
    .stb        (stb),
    .acqStart   (acqStart),
    .calEnable  (calEnable),
    .calDrive   (calDrive),
    .busy       (busy),
    .calibrated (calibrated)
  );

  wcal_dp #(.W(W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cfgTarget     (cfgTarget),
    .cfgWindowInit (cfgWindowInit),
    .acqValue      (acqValue),
    .window        (acqWindow),
    .spanMatch     (spanMatch),
    .lastStep      (lastStep),
    .outValid      (outValid),
    .outData       (outData)
  );

endmodule

// File: tb/span_cal_ctrl_bench.sv
`timescale 1ns/1ps
module span_cal_ctrl_bench;

  localparam int W    = 16;
  localparam int SOAK = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] cfgTarget = '0;
  logic [W-1:0] cfgWindowInit = '0;
  logic         recalReq = 1'b0;
  logic         acqStart;
  logic [W-1:0] acqWindow;
  logic         acqDone = 1'b0;
  logic [W-1:0] acqValue = '0;
  logic         calEnable, calDrive, busy, calibrated, outValid;
  logic [W-1:0] outData;

  span_cal_ctrl #(.W(W), .SOAK_CYCLES(SOAK)) u_span_cal_ctrl (
    .clk(clk), .rstN(rstN), .cfgTarget(cfgTarget), .cfgWindowInit(cfgWindowInit),
    .recalReq(recalReq), .acqStart(acqStart), .acqWindow(acqWindow),
    .acqDone(acqDone), .acqValue(acqValue), .calEnable(calEnable),
    .calDrive(calDrive), .busy(busy), .calibrated(calibrated),
    .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lvlTime = 0;
  logic [1:0] lvlPrev = 2'b10;

  // bench state shared between the front-end model and the main sequence
  bit abandon = 1'b1;
  bit runSeen = 1'b0;
  bit expectDrv = 1'b0;
  int runWin = 0;
  int calAcqs = 0;
  int firstCalWin = -1;
  int runCount = 0;
  int expLow = 0;
  int expTgt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mLow(input int win);
    return 5 + (win >> 2);
  endfunction

  function automatic int mHigh(input int win);
    return 5 + win - (win >> 2);
  endfunction

  function automatic int clampRef(input int raw, input int low, input int tgt);
    int d;
    d = raw - low;
    if (d < 0) return 0;
    if (d > tgt) return tgt;
    return d;
  endfunction

  // independent model of the search: final window, stored low, passes
  task automatic refSearch(input int init, input int tgt, output int win, output int lo, output int iters);
    int step, hi, span;
    bit fin;
    win = init; step = init >> 1; iters = 0; lo = 0; fin = 1'b0;
    while (!fin) begin
      lo = mLow(win); hi = mHigh(win); span = hi - lo; iters++;
      if (span == tgt) fin = 1'b1;
      else begin
        if (span > tgt) win = win - step; else win = win + step;
        step = step >> 1;
        if (step == 0) fin = 1'b1;
      end
    end
  endtask

  // cycle counter and level-change tracker, just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    if ({calEnable, calDrive} != lvlPrev) lvlTime = cyc;
    lvlPrev = {calEnable, calDrive};
  end

  // front-end model, acting on falling edges
  initial forever begin
    @(negedge clk);
    while (acqStart) begin
      bit en, drv;
      int win, raw, lat;
      en = calEnable; drv = calDrive; win = int'(acqWindow);
      if (en) begin
        calAcqs++;
        chk(drv == expectDrv, "R2 level order", int'(drv), int'(expectDrv));
        expectDrv = !expectDrv;
        chk((cyc - lvlTime) >= SOAK, "R3 soak length", cyc - lvlTime, SOAK);
        if (firstCalWin < 0) firstCalWin = win;
        raw = drv ? mHigh(win) : mLow(win);
      end else begin
        if (!abandon) begin
          if (!runSeen) begin runWin = win; runSeen = 1'b1; end
          else chk(win == runWin, "R7 run window", win, runWin);
        end
        raw = int'($urandom_range(expLow + expTgt + 40, 0));
      end
      lat = int'($urandom_range(4, 1));
      repeat (lat) @(negedge clk);
      acqValue = W'(raw);
      acqDone = 1'b1;
      @(negedge clk);
      acqDone = 1'b0;
      if (!en && !abandon) begin
        chk(outValid == 1'b1, "R8 valid pulse", int'(outValid), 1);
        chk(int'(outData) == clampRef(raw, expLow, expTgt), "R8 corrected value",
            int'(outData), clampRef(raw, expLow, expTgt));
        runCount++;
      end
    end
  end

  task automatic waitCal();
    while (!calibrated) begin @(posedge clk); #1; end
  endtask

  task automatic doCal(input int tgt, input int init, input bit viaRecal);
    int ew, el, ei, base;
    refSearch(init, tgt, ew, el, ei);
    cfgTarget = W'(tgt);
    cfgWindowInit = W'(init);
    abandon = 1'b1;
    runSeen = 1'b0;
    calAcqs = 0;
    expectDrv = 1'b0;
    firstCalWin = -1;
    expLow = el;
    expTgt = tgt;
    if (viaRecal) begin
      recalReq = 1'b1;
      @(posedge clk); #1;
      recalReq = 1'b0;
      chk(busy && !calibrated, "R9 restart flags", int'({busy, calibrated}), 2);
    end else begin
      rstN = 1'b1;
    end
    waitCal();
    abandon = 1'b0;
    chk(calEnable == 1'b0, "R7 pin released", int'(calEnable), 0);
    chk(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
    chk(calAcqs == 2 * ei, "R4 R6 pass count", calAcqs, 2 * ei);
    chk(firstCalWin == init, "R1 initial window", firstCalWin, init);
    while (!runSeen) begin @(posedge clk); #1; end
    chk(runWin == ew, "R5 final window", runWin, ew);
    base = runCount;
    while (runCount < base + 15) begin @(posedge clk); #1; end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(busy && !calibrated && calEnable && !calDrive && !acqStart && !outValid,
        "R1 reset state", int'({busy, calibrated, calEnable, calDrive, acqStart, outValid}), 6'b101000);
    @(posedge clk); #1;

    // exact span on the first pass: 400 -> span 200
    doCal(200, 400, 1'b0);

    // configuration changes after sampling must not matter
    cfgTarget = W'(3);
    cfgWindowInit = W'(9);
    base = runCount;
    while (runCount < base + 10) begin @(posedge clk); #1; end
    chk(runWin == 400 && int'(acqWindow) == 400, "R10 window held", int'(acqWindow), 400);

    // recal with a full binary search
    doCal(300, 256, 1'b1);
    // target unreachable: the step runs out
    doCal(1000, 100, 1'b1);
    // zero initial step: a single pass
    doCal(50, 1, 1'b1);

    // random configurations, each started by a recal while a conversion is in flight
    for (int k = 0; k < 4; k++) begin
      int t, i;
      t = int'($urandom_range(2500, 1));
      i = int'($urandom_range(3000, 2));
      while (!acqStart) begin @(posedge clk); #1; end
      @(posedge clk); #1;
      doCal(t, i, 1'b1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule